// File: doc/BRIEF.md
# Interrupt Affinity Routing Table

This block holds one 64-bit routing register for every shared interrupt above the private range. It sits on a memory-mapped register bus. Each access carries a byte offset inside the register window and is either 32 or 64 bits wide. The register index is the offset divided by eight. For each shared interrupt the block stores only the low 24 affinity bits, which cover affinity levels 0, 1 and 2.

A write to an entry resolves its target core straight away. The written affinity is compared with a small table of per-core affinity values, and the block keeps the resolved core index together with a valid flag. The distribution logic reads these resolved targets directly from flat output vectors.

The slots for the private interrupts share the same address window but are inert. The upper word of every register is inert. Offsets past the configured interrupt count are also inert.

Top module: `aff_route_table`

## Requirements
- R1: After reset every stored affinity is zero, every resolved core index and valid flag is zero, and `rdValid` is low.
- R2: A read (`busValid`=1, `busWrite`=0) returns its data on `rdData` with `rdValid` high on the cycle after the access; in any cycle that follows a non-read, `rdValid` is low.
- R3: A write keeps only write-data bits 23:0 and drops all higher bits; a read at byte offset 0 returns zero in bits 63:24.
- R4: `busSize`=1 selects a 64-bit access and `busSize`=0 a 32-bit access; both widths write the entry when address bit 2 is 0.
- R5: Any write with address bit 2 set is ignored, and a 32-bit read with address bit 2 set returns zero.
- R6: Read data equals the stored 24-bit value, zero-extended to 64 bits, shifted right by eight times address bits 2:0; for a 32-bit access, bits 63:32 are forced to zero.
- R7: On a write, the resolved core becomes the lowest-numbered core whose 24-bit affinity input equals the written affinity, and the valid flag is set.
- R8: When no core matches the written affinity, the valid flag of that entry is cleared.
- R9: The target is resolved only at write time; changing the per-core affinity inputs afterwards leaves every resolved target unchanged.
- R10: Slots 0 to NUM_PRIV-1 read as zero and ignore writes.
- R11: Slot index = address bits above bit 2. Slot NUM_PRIV+n drives `routeCore[n*CORE_W +: CORE_W]` and `routeOk[n]`. Slots at or above NUM_IRQ read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| busAddr | input | ADDR_W | Byte offset inside the routing window |
| busWdata | input | 64 | Write data, right-aligned to the access |
| coreAff | input | NUM_CORES*24 | Affinity value of each core, core c at bits c*24 |
| rdValid | output | 1 | Read data valid |
| rdData | output | 64 | Read data |
| routeCore | output | NUM_SPI*CORE_W | Resolved core index per shared interrupt |
| routeOk | output | NUM_SPI | Resolved target valid per shared interrupt |

## Verification
The bench uses the default build: 64 interrupt IDs, of which 32 are private, four cores and a 12-bit offset. This leaves 32 live entries. The offset reaches well past the last entry, so out-of-range slots can be exercised. Four cores are enough to give two cores the same affinity, which tests the lowest-index rule. The same build also makes it possible to write affinities that match no core at all.

// File: rtl/aff_route_pkg.sv
package aff_route_pkg;
  localparam int AFF_BITS = 24;

  typedef struct packed {
    logic       wrStb;
    logic       rdStb;
    logic       hit;
    logic       wide;
    logic [2:0] byteOff;
  } busStb_t;
endpackage

// File: rtl/aff_route_ctrl.sv
module aff_route_ctrl
  import aff_route_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 5
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busSize,
  input  logic [ADDR_W-1:0] busAddr,
  output busStb_t           stb,
  output logic [IDX_W-1:0]  spiIdx
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slotRaw;
  logic              inRange;

  assign slotRaw = busAddr[ADDR_W-1:3];
  assign inRange = (int'(slotRaw) >= NUM_PRIV) && (int'(slotRaw) < NUM_IRQ);
  assign spiIdx  = IDX_W'(slotRaw - SLOT_W'(NUM_PRIV));

  always_comb begin
    stb.wrStb   = busValid && busWrite && inRange && !busAddr[2];
    stb.rdStb   = busValid && !busWrite;
    stb.hit     = inRange;
    stb.wide    = busSize;
    stb.byteOff = busAddr[2:0];
  end
endmodule

// File: rtl/aff_route_dp.sv
module aff_route_dp
  import aff_route_pkg::*;
#(
  parameter int NUM_SPI   = 32,
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 5,
  parameter int CORE_W    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  busStb_t                       stb,
  input  logic [IDX_W-1:0]              spiIdx,
  input  logic [AFF_BITS-1:0]           wrAff,
  input  logic [NUM_CORES*AFF_BITS-1:0] coreAff,
  output logic                          rdValid,
  output logic [63:0]                   rdData,
  output logic [NUM_SPI*CORE_W-1:0]     routeCore,
  output logic [NUM_SPI-1:0]            routeOk
);
  logic [AFF_BITS-1:0] affTab  [NUM_SPI];
  logic [CORE_W-1:0]   coreTab [NUM_SPI];
  logic [NUM_SPI-1:0]  okTab;
  logic [NUM_CORES-1:0] hitVec;
  logic [CORE_W-1:0]   encCore;
  logic [AFF_BITS-1:0] selAff;
  logic [63:0]         shifted;
  logic [63:0]         rdNext;

  // per-core comparators
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_match
    assign hitVec[c] = (coreAff[c*AFF_BITS +: AFF_BITS] == wrAff);
  end

  // lowest index wins
  always_comb begin
    encCore = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (hitVec[c]) encCore = CORE_W'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SPI; i++) begin
        affTab[i]  <= '0;
        coreTab[i] <= '0;
      end
      okTab <= '0;
    end else if (stb.wrStb) begin
      affTab[spiIdx]  <= wrAff;
      coreTab[spiIdx] <= encCore;
      okTab[spiIdx]   <= |hitVec;
    end
  end

  always_comb begin
    selAff  = (int'(spiIdx) < NUM_SPI) ? affTab[spiIdx] : '0;
    shifted = {{(64 - AFF_BITS){1'b0}}, selAff} >> {stb.byteOff, 3'b000};
    if (!stb.hit)      rdNext = '0;
    else if (stb.wide) rdNext = shifted;
    else               rdNext = {32'h0, shifted[31:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdStb;
      rdData  <= stb.rdStb ? rdNext : '0;
    end
  end

  for (genvar i = 0; i < NUM_SPI; i++) begin : g_out
    assign routeCore[i*CORE_W +: CORE_W] = coreTab[i];
  end
  assign routeOk = okTab;
endmodule

// File: rtl/aff_route_table.sv
module aff_route_table
  import aff_route_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_PRIV  = 32,
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12,
  localparam int NUM_SPI  = NUM_IRQ - NUM_PRIV,
  localparam int IDX_W    = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busValid,
  input  logic                          busWrite,
  input  logic                          busSize,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [63:0]                   busWdata,
  input  logic [NUM_CORES*AFF_BITS-1:0] coreAff,
  output logic                          rdValid,
  output logic [63:0]                   rdData,
  output logic [NUM_SPI*CORE_W-1:0]     routeCore,
  output logic [NUM_SPI-1:0]            routeOk
);
  busStb_t          stb;
  logic [IDX_W-1:0] spiIdx;

  aff_route_ctrl #(
    .NUM_IRQ(NUM_IRQ), .NUM_PRIV(NUM_PRIV), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) ctrlInst (
    .busValid(busValid), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .stb(stb), .spiIdx(spiIdx)
  );

  aff_route_dp #(
    .NUM_SPI(NUM_SPI), .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .CORE_W(CORE_W)
  ) dpInst (
    .clk(clk), .rstN(rstN), .stb(stb), .spiIdx(spiIdx),
    .wrAff(busWdata[AFF_BITS-1:0]), .coreAff(coreAff),
    .rdValid(rdValid), .rdData(rdData),
    .routeCore(routeCore), .routeOk(routeOk)
  );
endmodule

// File: rtl/aff_route_chk.sv
module aff_route_chk #(
  parameter int NUM_PRIV = 32,
  parameter int ADDR_W   = 12,
  parameter int NUM_SPI  = 32,
  parameter int CORE_W   = 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busValid,
  input logic                      busWrite,
  input logic                      busSize,
  input logic [ADDR_W-1:0]         busAddr,
  input logic                      rdValid,
  input logic [63:0]               rdData,
  input logic [NUM_SPI*CORE_W-1:0] routeCore,
  input logic [NUM_SPI-1:0]        routeOk
);
  logic isRead, isWrite, isPriv;
  assign isRead  = busValid && !busWrite;
  assign isWrite = busValid && busWrite;
  assign isPriv  = int'(busAddr[ADDR_W-1:3]) < NUM_PRIV;

  // R2
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRead |=> rdValid);
  // R2
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> !rdValid);
  // R3
  aff_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRead && (busAddr[2:0] == 3'd0) |=> rdData[63:24] == 40'h0);
  // R6
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRead && !busSize |=> rdData[63:32] == 32'h0);
  // R5
  upper_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    isWrite && busAddr[2] |=> $stable(routeCore) && $stable(routeOk));
  // R5
  upper_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRead && busAddr[2] && !busSize |=> rdData == 64'h0);
  // R10
  priv_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    isWrite && isPriv |=> $stable(routeCore) && $stable(routeOk));
  // R10
  priv_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRead && isPriv |=> rdData == 64'h0);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isWrite |=> $stable(routeCore) && $stable(routeOk));
endmodule

bind aff_route_table aff_route_chk #(
  .NUM_PRIV(NUM_PRIV), .ADDR_W(ADDR_W), .NUM_SPI(NUM_SPI), .CORE_W(CORE_W)
) chkInst (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busSize(busSize), .busAddr(busAddr), .rdValid(rdValid), .rdData(rdData),
  .routeCore(routeCore), .routeOk(routeOk)
);

// File: tb/aff_route_table_test.sv
module aff_route_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 64, NPRIV = 32, NCORE = 4, AW = 12;
  localparam int NSPI = NIRQ - NPRIV;
  localparam int CW = 2;

  logic clk = 0, rstN = 0;
  logic busValid = 0, busWrite = 0, busSize = 0;
  logic [AW-1:0] busAddr = '0;
  logic [63:0] busWdata = '0;
  logic [23:0] tbAff [NCORE];
  logic [NCORE*24-1:0] coreAff;
  logic rdValid;
  logic [63:0] rdData;
  logic [NSPI*CW-1:0] routeCore;
  logic [NSPI-1:0] routeOk;

  int errors = 0, checks = 0;
  bit cmpOn = 0;
  int mAff [NSPI];
  int mCore [NSPI];
  bit mOk [NSPI];

  for (genvar c = 0; c < NCORE; c++) begin : g_aff
    assign coreAff[c*24 +: 24] = tbAff[c];
  end

  aff_route_table uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .coreAff(coreAff), .rdValid(rdValid), .rdData(rdData),
    .routeCore(routeCore), .routeOk(routeOk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R7 R8 R9: resolved targets compared every cycle
  always @(negedge clk) begin
    if (cmpOn) begin
      for (int i = 0; i < NSPI; i++) begin
        check64("R7/R9 core", 64'(routeCore[i*CW +: CW]), 64'(mCore[i]));
        check64("R8/R9 ok", 64'(routeOk[i]), 64'(mOk[i]));
      end
    end
  end

  function automatic logic [63:0] expRead(int addr, bit wide);
    int slot = addr / 8;
    logic [63:0] v;
    if (slot < NPRIV || slot >= NIRQ) return 64'h0;  // R10 R11
    v = 64'(mAff[slot - NPRIV]) >> (8 * (addr % 8));
    if (!wide) v = {32'h0, v[31:0]};
    return v;
  endfunction

  task automatic access(bit wr, bit wide, int addr, logic [63:0] data, string req);
    logic [63:0] exp;
    int slot;
    @(negedge clk);
    busValid = 1; busWrite = wr; busSize = wide;
    busAddr = AW'(addr); busWdata = data;
    exp = expRead(addr, wide);
    @(posedge clk); #1;
    slot = addr / 8;
    if (wr && (addr % 8) < 4 && slot >= NPRIV && slot < NIRQ) begin
      int s = slot - NPRIV;
      mAff[s] = int'(data[23:0]);
      mOk[s] = 0; mCore[s] = 0;
      for (int c = NCORE - 1; c >= 0; c--)
        if (tbAff[c] == data[23:0]) begin mOk[s] = 1; mCore[s] = c; end
    end
    check64({req, " R2 valid"}, 64'(rdValid), 64'(!wr));
    if (!wr) check64(req, rdData, exp);
    busValid = 0; busWrite = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    tbAff[0] = 24'h000100; tbAff[1] = 24'h010200;
    tbAff[2] = 24'h000102; tbAff[3] = 24'h000100;
    for (int i = 0; i < NSPI; i++) begin mAff[i] = 0; mCore[i] = 0; mOk[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    check64("R1 rdValid", 64'(rdValid), 0);
    check64("R1 routeOk", 64'(routeOk), 0);
    check64("R1 routeCore", 64'(routeCore), 0);
    cmpOn = 1;
    access(0, 1, 32*8, 0, "R1 entry read");
    // R3 R4 R7: 64-bit write, upper garbage dropped
    access(1, 1, 32*8, 64'hDEAD_BEEF_FF01_0200, "R4 wr64");
    access(0, 1, 32*8, 0, "R3 readback");
    // R4 R7: 32-bit write
    access(1, 0, 40*8, 64'h0000_0000_AB00_0102, "R4 wr32");
    access(0, 0, 40*8, 0, "R4 read32");
    // R7 duplicate affinity -> lowest core
    access(1, 0, 41*8, 64'h100, "R7 dup");
    // R8 no match
    access(1, 1, 42*8, 64'h123456, "R8 nomatch");
    access(0, 1, 42*8, 0, "R8 read");
    // R5 upper word inert
    access(1, 0, 32*8 + 4, 64'h102, "R5 wr upper32");
    access(1, 1, 32*8 + 4, 64'h102, "R5 wr upper64");
    access(0, 0, 32*8 + 4, 0, "R5 read upper");
    access(0, 1, 32*8, 0, "R5 entry kept");
    // R6 byte offset shift
    access(0, 0, 32*8 + 1, 0, "R6 off1");
    access(0, 1, 32*8 + 2, 0, "R6 off2");
    // R10 private slots
    access(1, 1, 5*8, 64'h010200, "R10 wr priv");
    access(0, 1, 5*8, 0, "R10 read priv");
    // R11 beyond range and last slot
    access(1, 1, 64*8, 64'h010200, "R11 wr beyond");
    access(0, 1, 64*8, 0, "R11 read beyond");
    access(1, 1, 63*8, 64'h000102, "R11 last slot");
    access(0, 1, 63*8, 0, "R11 read last");
    // R9 changing core affinities keeps targets
    @(negedge clk);
    tbAff[1] = 24'h777777; tbAff[2] = 24'h010200;
    repeat (3) @(posedge clk);
    check64("R9 slot32 core", 64'(routeCore[0 +: CW]), 64'd1);
    access(0, 1, 32*8, 0, "R9 read");
    // mixed traffic
    for (int n = 0; n < 300; n++) begin
      int a = $urandom_range(0, 4095);
      logic [63:0] d = {$urandom, $urandom};
      if (n % 3 == 0) d[23:0] = tbAff[$urandom_range(0, NCORE-1)];
      access($urandom_range(0, 1), $urandom_range(0, 1), a, d, "R6 mixed");
    end
    @(negedge clk);
    cmpOn = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule